// File: doc/BRIEF.md
# Masked Trigger Word Matcher

This block watches a stream of captured samples and raises a trigger flag when the low byte of a sample fits a programmed pattern. Each pattern bit is described by two bits: a reference bit and a mask bit. Depending on these two bits, a data bit must equal the reference, is ignored, or can never be satisfied. Setting a bit to "never" is how the host turns triggering off.

The reference word and the mask word share one 8-bit configuration bus. The reference word is captured when the load strobe rises. After that, the bus must keep presenting the mask word.

A qualifier input chooses between two rules. Under the first rule, one matching sample is enough. Under the second, two consecutive matching samples are needed. An arm input blocks every match during initialization. Once set, the trigger flag holds until master reset. Master reset does not disturb the stored reference word.

Top module: `trig_word_matcher`

## Requirements
- R1: While reset is asserted and right after it is released, `trig_flag` is 0.
- R2: Bit i is an exact bit when `cfg_bus[i]` is 0. An exact bit is satisfied only when `smp_data[i]` equals bit i of the stored reference word.
- R3: Bit i is a don't-care bit when `cfg_bus[i]` is 1 and reference bit i is 1. A don't-care bit is satisfied for every data value.
- R4: Bit i is a never bit when `cfg_bus[i]` is 1 and reference bit i is 0. A pattern with any never bit matches no data value at all.
- R5: A sample matches only when all 8 bits are satisfied in the same sample.
- R6: The reference word is taken from `cfg_bus` at the first rising clock edge where `word_ld` is seen high after being low (or after reset). Holding `word_ld` high does not reload the word.
- R7: A clock edge with `smp_en` high is a sample. A sample taken while `arm` is low never sets the flag, and it clears any pending first match.
- R8: With `dual_qual` low, one armed matching sample sets `trig_flag` at that same clock edge.
- R9: With `dual_qual` high, the flag is set only on the second of two consecutive armed matching samples. Clock edges with `smp_en` low lie between samples and do not break the pair.
- R10: With `dual_qual` high, a non-matching sample between two matches restarts qualification.
- R11: Once set, `trig_flag` stays 1 whatever the inputs do, until reset.
- R12: Reset keeps the stored reference word. After reset, matching works without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| smp_en | input | 1 | Marks a clock edge as a sample |
| smp_data | input | 8 | Low byte of the captured sample |
| cfg_bus | input | 8 | Shared bus: reference word during load, then the mask word |
| word_ld | input | 1 | Load strobe; its rising edge captures the reference word |
| dual_qual | input | 1 | 0: one match triggers, 1: two consecutive matches needed |
| arm | input | 1 | Allows matches to count |
| trig_flag | output | 1 | Sticky trigger indication |

## Verification
The assertions assume that every input changes only away from the rising clock edge. They also assume that `cfg_bus` carries the mask word whenever samples are taken after a load. The checks on never bits and don't-care bits are combinational, so they only make sense once a reference word has been stored.

The stimulus meets these assumptions in three ways. It drives every input on the falling edge. It always loads a reference word before the first sample. It moves the bus to the mask word on the cycle right after the load edge. Within those limits it sweeps all 256 data values across a dozen pattern settings and covers each timing case of the qualifier.

// File: rtl/tmw_pkg.sv
package tmw_pkg;

  typedef enum logic [1:0] {
    BIT_EXACT = 2'd0,
    BIT_ANY   = 2'd1,
    BIT_NEVER = 2'd2
  } bit_mode_e;

  function automatic bit_mode_e mode_of(input logic mask_bit, input logic ref_bit);
    if (!mask_bit)    return BIT_EXACT;
    else if (ref_bit) return BIT_ANY;
    else              return BIT_NEVER;
  endfunction

endpackage

// File: rtl/tmw_word_latch.sv
module tmw_word_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_ld,
  input  logic [W-1:0] cfg_bus,
  output logic [W-1:0] ref_word
);

  logic         ld_q;
  logic         ld_d;
  logic         ld_rise;
  logic [W-1:0] ref_d;

  always_comb begin
    ld_rise = word_ld & ~ld_q;
    ld_d    = word_ld;
    ref_d   = ld_rise ? cfg_bus : ref_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_q <= 1'b0;
    else        ld_q <= ld_d;
  end

  // Reference word deliberately has no reset (kept across master reset).
  always_ff @(posedge clk) begin
    if (ld_rise) ref_word <= ref_d;
  end

  // R6
  word_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> (ref_word == $past(cfg_bus)));

  // R6
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(word_ld) && word_ld) |-> !ld_rise);

endmodule

// File: rtl/tmw_bit_cell.sv
module tmw_bit_cell
  import tmw_pkg::*;
(
  input  logic mask_bit,
  input  logic ref_bit,
  input  logic data_bit,
  output logic bit_ok
);

  bit_mode_e mode;

  always_comb begin
    mode = mode_of(mask_bit, ref_bit);
    unique case (mode)
      BIT_EXACT: bit_ok = (data_bit == ref_bit);
      BIT_ANY:   bit_ok = 1'b1;
      default:   bit_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmw_qualifier.sv
module tmw_qualifier (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic arm,
  input  logic dual_qual,
  input  logic hit,
  output logic trig_flag
);

  logic hist_q, hist_d;
  logic flag_q, flag_d;
  logic armed_hit;
  logic fire;

  always_comb begin
    armed_hit = smp_en & arm & hit;
    fire      = armed_hit & (~dual_qual | hist_q);
    hist_d    = smp_en ? (arm & hit) : hist_q;
    flag_d    = flag_q | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      flag_q <= flag_d;
    end
  end

  assign trig_flag = flag_q;

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_flag |=> trig_flag);

  // R7
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_flag) |-> $past(smp_en && arm && hit));

  // R9
  dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trig_flag) && $past(dual_qual)) |-> $past(hist_q));

endmodule

// File: rtl/trig_word_matcher.sv
module trig_word_matcher #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] cfg_bus,
  input  logic              word_ld,
  input  logic              dual_qual,
  input  logic              arm,
  output logic              trig_flag
);

  localparam logic [DATA_W-1:0] ALL_SET = {DATA_W{1'b1}};

  logic [DATA_W-1:0] ref_word;
  logic [DATA_W-1:0] bit_ok;
  logic              hit;

  tmw_word_latch #(.W(DATA_W)) i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_ld  (word_ld),
    .cfg_bus  (cfg_bus),
    .ref_word (ref_word)
  );

  for (genvar g = 0; g < DATA_W; g++) begin : g_cell
    tmw_bit_cell i_cell (
      .mask_bit (cfg_bus[g]),
      .ref_bit  (ref_word[g]),
      .data_bit (smp_data[g]),
      .bit_ok   (bit_ok[g])
    );
  end

  assign hit = &bit_ok;

  tmw_qualifier i_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_en    (smp_en),
    .arm       (arm),
    .dual_qual (dual_qual),
    .hit       (hit),
    .trig_flag (trig_flag)
  );

  // R4
  never_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cfg_bus & ~ref_word)) |-> !hit);

  // R3
  all_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_bus & ref_word) == ALL_SET) |-> hit);

endmodule

// File: tb/test_trig_word_matcher.sv
module test_trig_word_matcher;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_en;
  logic [7:0] smp_data;
  logic [7:0] cfg_bus;
  logic       word_ld;
  logic       dual_qual;
  logic       arm;
  logic       trig_flag;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  trig_word_matcher i_trig_word_matcher (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data),
    .cfg_bus(cfg_bus), .word_ld(word_ld), .dual_qual(dual_qual),
    .arm(arm), .trig_flag(trig_flag)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: trig_flag=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_en = 1'b0; word_ld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [7:0] refw, input logic [7:0] mask);
    @(negedge clk);
    smp_en = 1'b0; cfg_bus = refw; word_ld = 1'b1;
    @(negedge clk);
    cfg_bus = mask; word_ld = 1'b0;
  endtask

  task automatic sample(input logic [7:0] d, input logic en, input logic a);
    @(negedge clk);
    smp_data = d; smp_en = en; arm = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic exp_hit(input logic [7:0] refw, input logic [7:0] mask,
                                   input logic [7:0] d);
    logic ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (mask[i]) begin
        if (!refw[i]) ok = 1'b0;
      end else if (d[i] != refw[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; smp_en = 1'b0; smp_data = '0; cfg_bus = '0;
    word_ld = 1'b0; dual_qual = 1'b0; arm = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(trig_flag, 1'b0, "R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk(trig_flag, 1'b0, "R1 after release");

    // Sweep all data values over several patterns (R2 R3 R4 R5 R8 R12)
    for (int k = 0; k < 12; k++) begin
      logic [7:0] rw, mk;
      string tag;
      case (k)
        0: begin rw = 8'hFF; mk = 8'hFF; end
        1: begin rw = 8'h7F; mk = 8'hFF; end
        2: begin rw = 8'hA5; mk = 8'h00; end
        3: begin rw = 8'h3C; mk = 8'h00; end
        default: begin rw = 8'((k * 37 + 11) % 256); mk = 8'((k * 91) % 256); end
      endcase
      if (|(mk & ~rw))  tag = "R4 never bit";
      else if (mk == 0) tag = "R2 R5 exact";
      else              tag = "R3 R5 masked";
      dual_qual = 1'b0;
      load(rw, mk);
      for (int d = 0; d < 256; d++) begin
        logic e;
        e = exp_hit(rw, mk, 8'(d));
        sample(8'(d), 1'b1, 1'b1);
        chk(trig_flag, e, tag);
        if (trig_flag) do_reset();   // R12: word kept across reset
      end
    end

    // R7: arm low blocks, then armed match fires (R8)
    do_reset(); dual_qual = 1'b0; load(8'h5A, 8'h00);
    sample(8'h5A, 1'b1, 1'b0); chk(trig_flag, 1'b0, "R7 unarmed match");
    sample(8'h5A, 1'b0, 1'b1); chk(trig_flag, 1'b0, "R7 no strobe");
    sample(8'h5A, 1'b1, 1'b1); chk(trig_flag, 1'b1, "R8 single match");

    // R11: sticky
    sample(8'h00, 1'b1, 1'b0); sample(8'h01, 1'b1, 1'b1);
    chk(trig_flag, 1'b1, "R11 sticky");
    do_reset(); @(posedge clk); #1 chk(trig_flag, 1'b0, "R11 reset clears");

    // R9: dual qualification with an idle gap
    dual_qual = 1'b1;
    sample(8'h5A, 1'b1, 1'b1); chk(trig_flag, 1'b0, "R9 first of pair");
    sample(8'h00, 1'b0, 1'b1); chk(trig_flag, 1'b0, "R9 idle gap");
    sample(8'h5A, 1'b1, 1'b1); chk(trig_flag, 1'b1, "R9 second of pair");

    // R10: break restarts
    do_reset(); dual_qual = 1'b1;
    sample(8'h5A, 1'b1, 1'b1);
    sample(8'h5B, 1'b1, 1'b1); chk(trig_flag, 1'b0, "R10 miss");
    sample(8'h5A, 1'b1, 1'b1); chk(trig_flag, 1'b0, "R10 restart");
    sample(8'h5A, 1'b1, 1'b1); chk(trig_flag, 1'b1, "R10 pair done");

    // R7: unarmed sample clears pending match
    do_reset(); dual_qual = 1'b1;
    sample(8'h5A, 1'b1, 1'b1);
    sample(8'h5A, 1'b1, 1'b0);
    sample(8'h5A, 1'b1, 1'b1); chk(trig_flag, 1'b0, "R7 pending cleared");

    // R6: held strobe loads only the first word
    do_reset(); dual_qual = 1'b0;
    @(negedge clk); cfg_bus = 8'h11; word_ld = 1'b1;
    @(negedge clk); cfg_bus = 8'h22;
    @(negedge clk); cfg_bus = 8'h00; word_ld = 1'b0;
    sample(8'h22, 1'b1, 1'b1); chk(trig_flag, 1'b0, "R6 second word ignored");
    sample(8'h11, 1'b1, 1'b1); chk(trig_flag, 1'b1, "R6 first word held");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule